// File: doc/BRIEF.md
# Serial Bit-Rate Tick Generator

This block produces the bit-rate tick for an asynchronous serial port from the oscillator clock. Each oscillator cycle goes through three counters in turn: a fixed divide-by-12 machine-cycle prescaler, then an 8-bit up-counting timer that reloads itself from a programmable value, then a final divider. The final divider counts 32 timer rollovers in normal rate, or 16 when the rate is doubled. The result is one tick every `N × (256 − reload)` oscillator clocks, where N is 384 or 192.

Software uses a byte-wide register port to program two registers: the reload value and a power-control byte. The top bit of the power-control byte asks for a doubled rate. The doubling is honoured only when the serial port reports a timer-driven mode. Two low bits of the same byte are sent out as idle and power-down request levels. Two further bits are plain flags that have no effect on the hardware.

Top module: `uart_rate_gen`

## Requirements
- R1: After reset both registers read 0x00, `idle_req` and `pdown_req` are 0, and `baud_tick` is 0.
- R2: The power-control register sits at address 0x87 and is only written as a whole byte. Bit 7 is the rate-double bit, bit 3 and bit 2 are free flags, bit 1 is power-down and bit 0 is idle. Bits 6 to 4 always read 0.
- R3: `idle_req` follows power-control bit 0 and `pdown_req` follows bit 1, starting the cycle after the write. The flag bits 3 and 2 change neither output.
- R4: The reload register at address 0x8D reads back the last byte written to it.
- R5: In normal rate, ticks are exactly 384 × (256 − reload) oscillator clocks apart.
- R6: When the rate-double bit is 1 and `ser_mode` is non-zero, ticks are exactly 192 × (256 − reload) clocks apart.
- R7: When `ser_mode` is 00 (shift-register mode), the rate-double bit is ignored and the normal period applies.
- R8: `baud_tick` is high for exactly one clock per period.
- R9: A change in the rate-double bit or in `ser_mode` takes effect at the next final-divider wrap. The interval that is already running finishes at its old length.
- R10: A new reload value is used at the next timer rollover, not earlier. With the timer at 0xFF, switching the reload from 0xFF to 0xFE right after a tick gives a transition interval of 12 + 31 × 24 = 756 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational, 0 for other addresses) |
| ser_mode | input | 2 | Current serial-port mode, where 00 means no doubling |
| baud_tick | output | 1 | One-clock rate tick |
| idle_req | output | 1 | Idle request level |
| pdown_req | output | 1 | Power-down request level |

## Verification
The bench measures tick spacing to the exact clock. An off-by-one in any of the three counters therefore shows up as a period of 383, 385 or a similar wrong value instead of 384. When doubling is switched on in the middle of an interval, the running interval must still be 384 clocks. A design that applied the change at once would produce a short interval. When the reload is changed while the timer sits at 0xFF, the transition interval must be exactly 756 clocks. A design that wrote the new reload straight into the timer would give a different count. The bench also sets the rate-double bit while `ser_mode` is 00 and checks that the period stays at 384. It writes 0xFF to the power-control byte to confirm that the reserved bits read 0. It writes only the flag bits to confirm that neither request output changes.

// File: rtl/uart_rate_gen.sv
module uart_rate_gen #(
  parameter int         PRESCALE  = 12,
  parameter logic [7:0] PCTL_ADDR = 8'h87,
  parameter logic [7:0] RLD_ADDR  = 8'h8D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [1:0] ser_mode,
  output logic       baud_tick,
  output logic       idle_req,
  output logic       pdown_req
);
  localparam int PW = $clog2(PRESCALE);

  logic [PW-1:0] pre_cnt;
  logic [7:0]    pctl_q, reload_q, tmr_q;
  logic [4:0]    fin_cnt;
  logic          dbl_act;

  wire mc_tick  = (pre_cnt == PW'(PRESCALE - 1));
  wire roll     = mc_tick && (tmr_q == 8'hFF);
  wire [4:0] fin_last = dbl_act ? 5'd15 : 5'd31;
  wire wrap     = roll && (fin_cnt == fin_last);
  wire dbl_req  = pctl_q[7] && (ser_mode != 2'b00);

  assign idle_req  = pctl_q[0];
  assign pdown_req = pctl_q[1];

  always_comb begin
    if (reg_addr == PCTL_ADDR)     reg_rdata = pctl_q;
    else if (reg_addr == RLD_ADDR) reg_rdata = reload_q;
    else                           reg_rdata = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pctl_q   <= 8'h00;
      reload_q <= 8'h00;
    end else if (reg_wr) begin
      if (reg_addr == PCTL_ADDR) pctl_q   <= reg_wdata & 8'h8F;
      if (reg_addr == RLD_ADDR)  reload_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt   <= '0;
      tmr_q     <= 8'h00;
      fin_cnt   <= 5'd0;
      dbl_act   <= 1'b0;
      baud_tick <= 1'b0;
    end else begin
      baud_tick <= wrap;
      pre_cnt   <= mc_tick ? '0 : pre_cnt + 1'b1;
      if (mc_tick) tmr_q <= (tmr_q == 8'hFF) ? reload_q : tmr_q + 8'd1;
      if (roll) begin
        if (wrap) begin
          fin_cnt <= 5'd0;
          dbl_act <= dbl_req;
        end else begin
          fin_cnt <= fin_cnt + 5'd1;
        end
      end
    end
  end

  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);                                          // R8
  AST_TICK_FROM_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> $past(roll));                                         // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == PCTL_ADDR) |-> (reg_rdata[6:4] == 3'b000));            // R2
  AST_REQ_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == PCTL_ADDR) |=>
      (idle_req == $past(reg_wdata[0]) && pdown_req == $past(reg_wdata[1]))); // R3
  AST_DBL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(dbl_act));                                        // R9
  AST_RELOAD_ON_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> (tmr_q == $past(reload_q)));                               // R10
endmodule

// File: tb/uart_rate_gen_test.sv
module uart_rate_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [1:0] ser_mode = 2'b01;
  logic       baud_tick, idle_req, pdown_req;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int last_tick = 0;

  uart_rate_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_mode(ser_mode),
    .baud_tick(baud_tick), .idle_req(idle_req), .pdown_req(pdown_req)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // returns clocks since previous observed tick; leaves time at tick's negedge
  task automatic wait_tick(output int gap);
    int prev = last_tick;
    do @(negedge clk); while (!baud_tick);
    last_tick = cyc;
    gap = last_tick - prev;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd_reg(8'h87, d); check("R1 pctl", d, 0);
    rd_reg(8'h8D, d); check("R1 reload", d, 0);
    check("R1 idle", idle_req, 0);
    check("R1 pdown", pdown_req, 0);
    check("R1 tick", baud_tick, 0);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr_reg(8'h87, 8'hFF);
    rd_reg(8'h87, d); check("R2 readback", d, 8'h8F);
    check("R3 idle set", idle_req, 1);
    check("R3 pdown set", pdown_req, 1);
    wr_reg(8'h87, 8'h0C);
    rd_reg(8'h87, d); check("R2 flags", d, 8'h0C);
    check("R3 flags no idle", idle_req, 0);
    check("R3 flags no pdown", pdown_req, 0);
    wr_reg(8'h87, 8'h00);
    wr_reg(8'h8D, 8'hA5);
    rd_reg(8'h8D, d); check("R4 reload A5", d, 8'hA5);
    wr_reg(8'h8D, 8'hFF);
    rd_reg(8'h8D, d); check("R4 reload FF", d, 8'hFF);
  endtask

  task automatic t_normal;
    int g;
    wait_tick(g); wait_tick(g); wait_tick(g);
    check("R5 period FF", g, 384);
    @(negedge clk); check("R8 one cycle", baud_tick, 0);
  endtask

  task automatic t_reload_change;
    int g;
    wait_tick(g);
    wr_reg(8'h8D, 8'hFE);
    wait_tick(g); check("R10 transition", g, 756);
    wait_tick(g); check("R5 period FE", g, 768);
    wr_reg(8'h8D, 8'hFF);
    wait_tick(g); wait_tick(g); check("R5 period FF again", g, 384);
  endtask

  task automatic t_double;
    int g;
    wait_tick(g);
    wr_reg(8'h87, 8'h80);
    wait_tick(g); check("R9 old length kept", g, 384);
    wait_tick(g); check("R6 doubled FF", g, 192);
    wait_tick(g); check("R6 doubled FF repeat", g, 192);
  endtask

  task automatic t_mode0;
    int g;
    wait_tick(g);
    ser_mode = 2'b00;
    wait_tick(g); check("R9 mode change deferred", g, 192);
    wait_tick(g); check("R7 mode 0 no double", g, 384);
    ser_mode = 2'b11;
    wait_tick(g); wait_tick(g); check("R6 mode 3 doubled", g, 192);
  endtask

  task automatic t_slow;
    int g;
    wait_tick(g);
    wr_reg(8'h8D, 8'hF0);
    wait_tick(g); check("R10 transition F0", g, 2892);
    wait_tick(g); check("R6 doubled F0", g, 3072);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_normal;
    t_reload_change;
    t_double;
    t_mode0;
    t_slow;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule